// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a fixed set of memory-mapped devices and tells the processor whether it should be interrupted now. Every device owns a small status word. It holds a ready flag and an interrupt-enable flag. Device hardware raises the ready flag with a one-cycle pulse and clears it with a clear strobe. Software reads the status word and can write only the enable flag. A device asks for service when both flags are set.

Each device has a fixed 3-bit urgency level and a fixed 8-bit vector, both given as parameters. Among the devices that are asking, the arbiter finds the most urgent one. It raises the interrupt output only if that device's level is strictly above the level of the program that is running, which arrives on an input. The winner's vector and level go out with the interrupt. All outputs are combinational from the registered flags and the current level, so the pipeline can sample them in any cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is asserted and right after it, every ready and enable flag is 0, `irq` is 0, and every status read returns 0.
- R2: A device requests only when its ready flag (status bit 15) and its enable flag (status bit 14) are both 1; one flag alone never raises `irq`.
- R3: Among requesting devices, the one with the numerically largest level wins (levels 0 lowest to 7 highest, 3 bits).
- R4: When several requesting devices share the top level, the one with the lowest device index wins.
- R5: `irq` is 1 only when the winner's level is strictly greater than `cur_level`; an equal or lower winner leaves `irq` at 0.
- R6: While `irq` is 1, `irq_vec` and `irq_prio` carry the winner's parameter vector and level; while `irq` is 0, both read as zero.
- R7: A write with `reg_wr` high and `reg_addr` equal to a device index loads status bit 14 of `reg_wdata` into that device's enable flag at the next edge. Every other data bit is ignored, and a write to an address at or above the device count changes nothing.
- R8: A pulse on a device's `ready_set` bit sets its ready flag at the next edge, and a pulse on its `ready_clr` bit clears it. If both arrive in the same cycle, set wins. With neither, the flag holds.
- R9: `reg_rdata` returns, in the same cycle, the flags of the device addressed by `reg_addr`: ready in bit 15, enable in bit 14, and zero in all other bits. An address at or above the device count reads all zeros.
- R10: A change of `cur_level` affects `irq`, `irq_vec` and `irq_prio` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_set | input | N_DEV | Per-device pulse from hardware that sets the ready flag |
| ready_clr | input | N_DEV | Per-device pulse that clears the ready flag |
| reg_wr | input | 1 | Status register write strobe |
| reg_addr | input | ADDR_W | Device index for register read and write |
| reg_wdata | input | 16 | Write data; only bit 14 is used |
| reg_rdata | output | 16 | Status word of the addressed device |
| cur_level | input | PRIO_W | Level of the running program |
| irq | output | 1 | Interrupt the processor |
| irq_vec | output | VEC_W | Vector of the winning device, zero when idle |
| irq_prio | output | PRIO_W | Level of the winning device, zero when idle |

## Verification
The assertions assume that the set and clear pulses and the write strobe are clean, synchronous, single-cycle-sampled levels with no X. They also assume that reset is held for at least one edge before any checking. The stimulus drives every input only at the falling edge. It uses `$urandom` for arbitrary mixes of pulses, writes, out-of-range addresses and levels. Set and clear are deliberately pulsed together on the same device, so the set-over-clear rule is exercised rather than avoided.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
   localparam int STAT_W    = 16;
   localparam int READY_BIT = 15;
   localparam int EN_BIT    = 14;

   typedef struct packed {
      logic ready;
      logic enable;
   } dev_flags_t;

   function automatic logic [STAT_W-1:0] pack_status(input dev_flags_t f);
      logic [STAT_W-1:0] w;
      w            = '0;
      w[READY_BIT] = f.ready;
      w[EN_BIT]    = f.enable;
      return w;
   endfunction
endpackage

// File: rtl/irq_dev_status.sv
`timescale 1ns/1ps
module irq_dev_status
   import irq_arb_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_enable_bit,
   input  logic              hw_set,
   input  logic              hw_clr,
   output dev_flags_t        flags,
   output logic              req
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(IDX);

   logic hit;
   assign hit = wr_strobe && (wr_addr == MY_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (hit)
            flags.enable <= wr_enable_bit;
         if (hw_set)
            flags.ready <= 1'b1;
         else if (hw_clr)
            flags.ready <= 1'b0;
      end
   end

   assign req = flags.ready & flags.enable;

   assert_en_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flags.enable == $past(wr_enable_bit));
   assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(flags.enable));
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flags.ready);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr && !hw_set) |=> !flags.ready);
   assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_clr && !hw_set) |=> $stable(flags.ready));
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
   parameter int                         N_DEV    = 4,
   parameter int                         PRIO_W   = 3,
   parameter int                         VEC_W    = 8,
   parameter logic [N_DEV*PRIO_W-1:0]    DEV_PRIO = '0,
   parameter logic [N_DEV*VEC_W-1:0]     DEV_VEC  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEV-1:0]  req,
   output logic              found,
   output logic [PRIO_W-1:0] win_prio,
   output logic [VEC_W-1:0]  win_vec,
   output logic [N_DEV-1:0]  grant
);
   always_comb begin
      found    = 1'b0;
      win_prio = '0;
      win_vec  = '0;
      grant    = '0;
      // strict compare in ascending order keeps the lowest index on ties
      for (int i = 0; i < N_DEV; i++) begin
         if (req[i] && (!found || DEV_PRIO[i*PRIO_W +: PRIO_W] > win_prio)) begin
            found    = 1'b1;
            win_prio = DEV_PRIO[i*PRIO_W +: PRIO_W];
            win_vec  = DEV_VEC[i*VEC_W +: VEC_W];
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_grant_is_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   assert_found_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> $countones(grant) == 1);
endmodule

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
module irq_level_gate #(
   parameter int PRIO_W = 3,
   parameter int VEC_W  = 8
) (
   input  logic              found,
   input  logic [PRIO_W-1:0] win_prio,
   input  logic [VEC_W-1:0]  win_vec,
   input  logic [PRIO_W-1:0] cur_level,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [PRIO_W-1:0] irq_prio
);
   always_comb begin
      irq      = found && (win_prio > cur_level);
      irq_vec  = irq ? win_vec  : '0;
      irq_prio = irq ? win_prio : '0;
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int                       N_DEV    = 4,
   parameter int                       ADDR_W   = 3,
   parameter int                       PRIO_W   = 3,
   parameter int                       VEC_W    = 8,
   parameter logic [N_DEV*PRIO_W-1:0]  DEV_PRIO = {3'd7, 3'd5, 3'd5, 3'd2},
   parameter logic [N_DEV*VEC_W-1:0]   DEV_VEC  = {8'hA0, 8'h90, 8'h81, 8'h80}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DEV-1:0]  ready_set,
   input  logic [N_DEV-1:0]  ready_clr,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic [PRIO_W-1:0] cur_level,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [PRIO_W-1:0] irq_prio
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_SPAN < N_DEV) begin : g_bad_addr
         $error("ADDR_W too narrow for N_DEV");
      end
      if (N_DEV < 1 || PRIO_W < 1 || VEC_W < 1) begin : g_bad_size
         $error("N_DEV, PRIO_W and VEC_W must be positive");
      end
      if (STAT_W != 16) begin : g_bad_stat
         $error("status word must be 16 bits");
      end
   endgenerate

   dev_flags_t             flags [N_DEV];
   logic [N_DEV-1:0]       req;
   logic                   found;
   logic [PRIO_W-1:0]      win_prio;
   logic [VEC_W-1:0]       win_vec;
   logic [N_DEV-1:0]       grant;

   generate
      for (genvar d = 0; d < N_DEV; d++) begin : g_dev
         irq_dev_status #(
            .ADDR_W (ADDR_W),
            .IDX    (d)
         ) u_stat (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_strobe     (reg_wr),
            .wr_addr       (reg_addr),
            .wr_enable_bit (reg_wdata[EN_BIT]),
            .hw_set        (ready_set[d]),
            .hw_clr        (ready_clr[d]),
            .flags         (flags[d]),
            .req           (req[d])
         );
      end
   endgenerate

   irq_prio_pick #(
      .N_DEV    (N_DEV),
      .PRIO_W   (PRIO_W),
      .VEC_W    (VEC_W),
      .DEV_PRIO (DEV_PRIO),
      .DEV_VEC  (DEV_VEC)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .found    (found),
      .win_prio (win_prio),
      .win_vec  (win_vec),
      .grant    (grant)
   );

   irq_level_gate #(
      .PRIO_W (PRIO_W),
      .VEC_W  (VEC_W)
   ) u_gate (
      .found     (found),
      .win_prio  (win_prio),
      .win_vec   (win_vec),
      .cur_level (cur_level),
      .irq       (irq),
      .irq_vec   (irq_vec),
      .irq_prio  (irq_prio)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < N_DEV; i++) begin
         if (reg_addr == ADDR_W'(i))
            reg_rdata = pack_status(flags[i]);
      end
   end

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (irq_vec == '0 && irq_prio == '0));
   assert_above_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_prio > cur_level);
   assert_irq_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> req != '0);
   assert_rdata_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[13:0] == '0);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (req == '0 && !irq));
endmodule

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] ready_set = '0;
   logic [N-1:0] ready_clr = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  cur_level = '0;
   logic        irq;
   logic [7:0]  irq_vec;
   logic [2:0]  irq_prio;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model state and fixed device table
   bit m_rdy [N];
   bit m_en  [N];
   int m_prio [N] = '{2, 5, 5, 7};
   int m_vec  [N] = '{8'h80, 8'h81, 8'h90, 8'hA0};

   always #4 clk = ~clk;

   irq_prio_arbiter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_set (ready_set),
      .ready_clr (ready_clr),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cur_level (cur_level),
      .irq       (irq),
      .irq_vec   (irq_vec),
      .irq_prio  (irq_prio)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      int best, win, e_irq, e_vec, e_prio, e_rd;
      best = -1; win = -1;
      for (int i = 0; i < N; i++)
         if (m_rdy[i] && m_en[i] && m_prio[i] > best) begin
            best = m_prio[i]; win = i;
         end
      e_irq  = (win >= 0 && best > int'(cur_level)) ? 1 : 0;
      e_vec  = e_irq ? m_vec[win] : 0;
      e_prio = e_irq ? best : 0;
      e_rd   = (int'(reg_addr) < N) ?
               ((int'(m_rdy[reg_addr]) << 15) | (int'(m_en[reg_addr]) << 14)) : 0;
      chk({tag, " irq"},   int'(irq), e_irq);
      chk({tag, " vec"},   int'(irq_vec), e_vec);
      chk({tag, " prio"},  int'(irq_prio), e_prio);
      chk({tag, " rdata"}, int'(reg_rdata), e_rd);
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_rdy[i] = 0; m_en[i] = 0; end
      end else begin
         if (reg_wr && int'(reg_addr) < N) m_en[reg_addr] = reg_wdata[14];
         for (int i = 0; i < N; i++) begin
            if (ready_set[i]) m_rdy[i] = 1;
            else if (ready_clr[i]) m_rdy[i] = 0;
         end
      end
   endtask

   // drive at negedge, check 1 ns later, let the edge commit, update model
   task automatic step(input logic [N-1:0] s, input logic [N-1:0] c, input logic w,
                       input logic [2:0] a, input logic [15:0] d, input logic [2:0] lvl,
                       input string tag);
      ready_set = s; ready_clr = c; reg_wr = w; reg_addr = a; reg_wdata = d;
      cur_level = lvl;
      #1;
      compare_all(tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_rdy[i] = 0; m_en[i] = 0; end
      @(negedge clk);
      // R1: reset state, with stimulus pushing on every input
      for (int a = 0; a < 4; a++)
         step(4'hF, 4'h0, 1'b1, 3'(a), 16'hFFFF, 3'd0, "R1 reset");
      rst_n = 1'b1;
      for (int a = 0; a < 4; a++)
         step('0, '0, 1'b0, 3'(a), '0, 3'd0, "R1 after reset");

      // R2: ready without enable, then enable without ready
      step(4'b0010, '0, 1'b0, 3'd1, '0, 3'd0, "R2 ready only");
      step('0, '0, 1'b0, 3'd1, '0, 3'd0, "R2 ready only");
      chk("R2 no irq on ready alone", int'(irq), 0);
      step('0, '0, 1'b1, 3'd3, 16'h4000, 3'd0, "R2 enable only");
      step('0, '0, 1'b0, 3'd3, '0, 3'd0, "R2 enable only");
      chk("R2 no irq on enable alone", int'(irq), 0);

      // R7/R6: enable device 1 with junk in other bits
      step('0, '0, 1'b1, 3'd1, 16'hBFFF, 3'd0, "R7 junk write");
      step('0, '0, 1'b0, 3'd1, '0, 3'd0, "R7 junk write");
      chk("R7 junk bits ignored", int'(reg_rdata), 16'h8000);
      step('0, '0, 1'b1, 3'd1, 16'h4000, 3'd0, "R7 enable dev1");
      step('0, '0, 1'b0, 3'd1, '0, 3'd0, "R6 dev1 wins");
      chk("R6 vector of dev1", int'(irq_vec), 8'h81);
      chk("R9 ready and enable", int'(reg_rdata), 16'hC000);

      // R5 and R10: level equal blocks, one lower passes, same cycle
      step('0, '0, 1'b0, 3'd1, '0, 3'd5, "R5 equal level");
      step('0, '0, 1'b0, 3'd1, '0, 3'd4, "R10 level drop");

      // R4: device 2 at the same level as device 1
      step(4'b0100, '0, 1'b1, 3'd2, 16'h4000, 3'd0, "R4 tie setup");
      step('0, '0, 1'b0, 3'd2, '0, 3'd0, "R4 tie");
      chk("R4 lowest index wins", int'(irq_vec), 8'h81);

      // R3: device 3 at level 7
      step(4'b1000, '0, 1'b1, 3'd3, 16'h4000, 3'd6, "R3 setup");
      step('0, '0, 1'b0, 3'd3, '0, 3'd6, "R3 highest");
      chk("R3 top level wins", int'(irq_prio), 7);

      // R8: set and clear together on dev3, then clear alone
      step('0, 4'b1000, 1'b0, 3'd3, '0, 3'd0, "R8 pre");
      step(4'b1000, 4'b1000, 1'b0, 3'd3, '0, 3'd0, "R8 both");
      step('0, '0, 1'b0, 3'd3, '0, 3'd0, "R8 set wins");
      chk("R8 set over clear", int'(reg_rdata[15]), 1);
      step('0, 4'b1000, 1'b0, 3'd3, '0, 3'd0, "R8 clear");
      step('0, '0, 1'b0, 3'd3, '0, 3'd0, "R8 cleared");
      chk("R8 ready cleared", int'(reg_rdata[15]), 0);

      // R9 and R7: out-of-range address reads zero, write ignored
      step('0, '0, 1'b1, 3'd6, 16'h0000, 3'd0, "R7 oob write");
      step('0, '0, 1'b0, 3'd6, '0, 3'd0, "R9 oob read");
      chk("R9 oob reads zero", int'(reg_rdata), 0);

      // random mix, compared against the model every cycle
      for (int k = 0; k < 4000; k++)
         step(4'($urandom & $urandom), 4'($urandom & $urandom), 1'($urandom % 3 == 0),
              3'($urandom), {1'b0, 1'($urandom), 14'($urandom)}, 3'($urandom), "R3 random");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule